// File: doc/BRIEF.md
# Boost LED Driver Start and Shutdown Sequencer

This block controls when the boost converter of an LED backlight driver may switch, and how it comes up and goes down. An internal run condition holds only while the standby input and three under-voltage good flags (supply, power-stage input and internal regulator) are all asserted. Once that condition holds, the soft start waits until both dimming inputs are high together. It then advances a digital ramp that stands in for the soft-start capacitor voltage. The ramp sets a numeric duty limit for the gate stage and decides when open-string detection may begin.

The gate stage is enabled only while the first dimming input is high. The dimming switch drive needs both dimming inputs high. When standby drops, switching stops at once. While the regulator is still good, the dimming drive keeps following the two dimming inputs and a discharge request is raised, so the output capacitor drains through the LEDs. When the regulator flag falls, everything goes quiet. A latch-off input, raised by fault logic outside this block, forces the ramp to zero and blocks switching and dimming.

Top module: `led_boost_seq`

## Requirements
- R1: The block runs only while `stb_i`, `vcc_ok_i`, `vin_ok_i` and `reg_ok_i` are all high. Dropping any one of them leaves the gate enable low.
- R2: The ramp stays at zero until the clock edge at which both `pwm1_i` and `pwm2_i` are sampled high together during run. The ramp may first increase one step interval after that edge.
- R3: If the run condition is low at a clock edge, the ramp is zero after that edge, and arming must then happen again.
- R4: `gate_en_o` is high only while `pwm1_i` is high. The level of `pwm2_i` has no effect on it.
- R5: `gate_en_o` stays low while the ramp is below MIN_LVL = floor(FULL*11/30), where FULL = 2^RAMP_W-1 is full scale.
- R6: `duty_lim_o` equals min(ramp, CAP) while the gate is enabled and 0 otherwise, with CAP = floor(FULL*DUTY_MAX_PCT/100).
- R7: While running and not latched off, `dim_o` = `pwm1_i` AND `pwm2_i`.
- R8: `open_en_o` is high exactly when the block is running, not latched off, and the ramp is at FULL.
- R9: While `stb_i` is low and both `reg_ok_i` and `vcc_ok_i` are high, `reg_dis_o` is high and `dim_o` = `pwm1_i` AND `pwm2_i`. Once `reg_ok_i` is low, `dim_o` and `reg_dis_o` are low.
- R10: While armed and running, the ramp increases by exactly 1 on every STEP_TICKS-th sampled `tick_i`, never changes by more than 1 per edge, and saturates at FULL.
- R11: While `latch_off_i` is high, the ramp is zero after each edge, and `gate_en_o`, `open_en_o` and (outside the discharge window) `dim_o` are low.
- R12: After standby returns high, a new soft start begins only after both dimming inputs are again sampled high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stb_i | input | 1 | Standby, high to enable |
| vcc_ok_i | input | 1 | Supply above under-voltage threshold |
| vin_ok_i | input | 1 | Power-stage input above under-voltage threshold |
| reg_ok_i | input | 1 | Internal regulator above under-voltage threshold |
| pwm1_i | input | 1 | Dimming input 1, also gates switching |
| pwm2_i | input | 1 | Dimming input 2 |
| latch_off_i | input | 1 | Fault latch-off state |
| tick_i | input | 1 | Oscillator tick strobe |
| gate_en_o | output | 1 | Gate switching allowed |
| duty_lim_o | output | RAMP_W | Duty limit, fraction of full scale |
| dim_o | output | 1 | Dimming switch drive |
| open_en_o | output | 1 | Open-string detection enabled |
| reg_dis_o | output | 1 | Regulator discharge request |
| ss_level_o | output | RAMP_W | Current soft-start ramp value |

## Verification
Stimulus first raises only `pwm1_i`, to show that arming needs both inputs together. It then toggles `pwm2_i` against a steady `pwm1_i`, which separates the gate rule from the dimming rule. Ramp growth is checked with a tick on every cycle and with a tick every third cycle, which exposes step-count errors, and is followed through the MIN_LVL threshold, the CAP clamp and saturation at FULL. Single-cycle drops of each good flag, a latch-off window, and a standby fall with the regulator first good and then failing separate the ramp discharge, the latch-off behaviour and the discharge dimming window from one another.

// File: rtl/seq_pkg.sv
package seq_pkg;
  function automatic int unsigned lvl_min(input int unsigned full);
    return (full * 11) / 30;
  endfunction

  function automatic int unsigned lvl_cap(input int unsigned full, input int unsigned pct);
    return (full * pct) / 100;
  endfunction
endpackage

// File: rtl/seq_arm.sv
module seq_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic pwm1_i,
  input  logic pwm2_i,
  output logic armed_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= run_i & (armed_q | (pwm1_i & pwm2_i));
  end

  assign armed_o = armed_q;

  AST_ARM_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !armed_o); // R12
endmodule

// File: rtl/seq_ramp.sv
module seq_ramp #(
  parameter int unsigned RAMP_W     = 8,
  parameter int unsigned STEP_TICKS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              armed_i,
  input  logic              latch_i,
  input  logic              tick_i,
  output logic [RAMP_W-1:0] ramp_o
);
  localparam int unsigned CNT_W = (STEP_TICKS > 1) ? $clog2(STEP_TICKS) : 1;
  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(STEP_TICKS - 1);
  localparam logic [RAMP_W-1:0] FULL     = {RAMP_W{1'b1}};

  logic [CNT_W-1:0]  cnt_q;
  logic [RAMP_W-1:0] ramp_q;
  logic              hold;

  assign hold = !run_i || latch_i || !armed_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      ramp_q <= '0;
    end else if (hold) begin
      cnt_q  <= '0;
      ramp_q <= '0;
    end else if (tick_i) begin
      if (cnt_q == CNT_LAST) begin
        cnt_q <= '0;
        if (ramp_q != FULL) ramp_q <= ramp_q + 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign ramp_o = ramp_q;

  AST_RAMP_DISCHARGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (ramp_o == '0)); // R3
  AST_RAMP_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_i |=> (ramp_o == '0)); // R11
  AST_RAMP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ramp_o > $past(ramp_o)) |-> (ramp_o == $past(ramp_o) + 1'b1)); // R10
  AST_RAMP_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ramp_o == FULL && !hold) |=> (ramp_o == FULL || !run_i || latch_i || !armed_i)); // R10
endmodule

// File: rtl/seq_drive.sv
module seq_drive #(
  parameter int unsigned       RAMP_W  = 8,
  parameter logic [RAMP_W-1:0] MIN_LVL = '0,
  parameter logic [RAMP_W-1:0] CAP_LVL = '1
) (
  input  logic              run_i,
  input  logic              stb_i,
  input  logic              vcc_ok_i,
  input  logic              reg_ok_i,
  input  logic              latch_i,
  input  logic              pwm1_i,
  input  logic              pwm2_i,
  input  logic [RAMP_W-1:0] ramp_i,
  output logic              gate_en_o,
  output logic [RAMP_W-1:0] duty_o,
  output logic              dim_o,
  output logic              open_en_o,
  output logic              dis_o
);
  localparam logic [RAMP_W-1:0] FULL = {RAMP_W{1'b1}};

  logic active, disch;

  assign active = run_i & ~latch_i;
  // discharge window: standby off, regulator still alive
  assign disch  = ~stb_i & reg_ok_i & vcc_ok_i;

  always_comb begin
    gate_en_o = active & pwm1_i & (ramp_i >= MIN_LVL);
    duty_o    = '0;
    if (gate_en_o) duty_o = (ramp_i > CAP_LVL) ? CAP_LVL : ramp_i;
    dim_o     = (active | disch) & pwm1_i & pwm2_i;
    open_en_o = active & (ramp_i == FULL);
    dis_o     = disch;
  end
endmodule

// File: rtl/led_boost_seq.sv
module led_boost_seq #(
  parameter int unsigned RAMP_W       = 8,
  parameter int unsigned STEP_TICKS   = 16,
  parameter int unsigned DUTY_MAX_PCT = 95
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_i,
  input  logic              vcc_ok_i,
  input  logic              vin_ok_i,
  input  logic              reg_ok_i,
  input  logic              pwm1_i,
  input  logic              pwm2_i,
  input  logic              latch_off_i,
  input  logic              tick_i,
  output logic              gate_en_o,
  output logic [RAMP_W-1:0] duty_lim_o,
  output logic              dim_o,
  output logic              open_en_o,
  output logic              reg_dis_o,
  output logic [RAMP_W-1:0] ss_level_o
);
  import seq_pkg::*;

  localparam int unsigned       FULL_I  = (1 << RAMP_W) - 1;
  localparam logic [RAMP_W-1:0] FULL    = RAMP_W'(FULL_I);
  localparam logic [RAMP_W-1:0] MIN_LVL = RAMP_W'(lvl_min(FULL_I));
  localparam logic [RAMP_W-1:0] CAP_LVL = RAMP_W'(lvl_cap(FULL_I, DUTY_MAX_PCT));

  logic              run;
  logic              armed;
  logic [RAMP_W-1:0] ramp;

  assign run = stb_i & vcc_ok_i & vin_ok_i & reg_ok_i;

  seq_arm u_arm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .pwm1_i  (pwm1_i),
    .pwm2_i  (pwm2_i),
    .armed_o (armed)
  );

  seq_ramp #(.RAMP_W(RAMP_W), .STEP_TICKS(STEP_TICKS)) u_ramp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .armed_i (armed),
    .latch_i (latch_off_i),
    .tick_i  (tick_i),
    .ramp_o  (ramp)
  );

  seq_drive #(.RAMP_W(RAMP_W), .MIN_LVL(MIN_LVL), .CAP_LVL(CAP_LVL)) u_drive (
    .run_i     (run),
    .stb_i     (stb_i),
    .vcc_ok_i  (vcc_ok_i),
    .reg_ok_i  (reg_ok_i),
    .latch_i   (latch_off_i),
    .pwm1_i    (pwm1_i),
    .pwm2_i    (pwm2_i),
    .ramp_i    (ramp),
    .gate_en_o (gate_en_o),
    .duty_o    (duty_lim_o),
    .dim_o     (dim_o),
    .open_en_o (open_en_o),
    .dis_o     (reg_dis_o)
  );

  assign ss_level_o = ramp;

  AST_GATE_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_en_o |-> (stb_i && vcc_ok_i && vin_ok_i && reg_ok_i)); // R1
  AST_GATE_THRESH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_en_o |-> (ss_level_o >= MIN_LVL)); // R5
  AST_DUTY_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    duty_lim_o <= CAP_LVL); // R6
  AST_OPEN_AT_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_en_o |-> (ss_level_o == FULL)); // R8
  AST_SHUT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_ok_i |-> (!dim_o && !reg_dis_o)); // R9
endmodule

// File: tb/led_boost_seq_tb.sv
module led_boost_seq_tb;
  localparam int W = 6;
  localparam int STEP = 2;
  localparam int PCT = 95;
  localparam int FULL = (1 << W) - 1;
  localparam int MINL = (FULL * 11) / 30;
  localparam int CAP = (FULL * PCT) / 100;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic stb_i = 0, vcc_ok_i = 0, vin_ok_i = 0, reg_ok_i = 0;
  logic pwm1_i = 0, pwm2_i = 0, latch_off_i = 0, tick_i = 0;
  logic gate_en_o, dim_o, open_en_o, reg_dis_o;
  logic [W-1:0] duty_lim_o, ss_level_o;

  int total = 0, bad = 0, tick_div = 1, cyc_n = 0;
  int m_ramp = 0, m_cnt = 0;
  bit m_armed = 0;

  always #2 clk_i = ~clk_i;

  led_boost_seq #(.RAMP_W(W), .STEP_TICKS(STEP), .DUTY_MAX_PCT(PCT)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .stb_i(stb_i), .vcc_ok_i(vcc_ok_i),
    .vin_ok_i(vin_ok_i), .reg_ok_i(reg_ok_i), .pwm1_i(pwm1_i), .pwm2_i(pwm2_i),
    .latch_off_i(latch_off_i), .tick_i(tick_i), .gate_en_o(gate_en_o),
    .duty_lim_o(duty_lim_o), .dim_o(dim_o), .open_en_o(open_en_o),
    .reg_dis_o(reg_dis_o), .ss_level_o(ss_level_o)
  );

  // behavioural reference
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_armed = 0; m_ramp = 0; m_cnt = 0;
    end else if (!(stb_i && vcc_ok_i && vin_ok_i && reg_ok_i)) begin
      m_armed = 0; m_ramp = 0; m_cnt = 0;
    end else begin
      bit nxt;
      nxt = m_armed || (pwm1_i && pwm2_i);
      if (latch_off_i || !m_armed) begin
        m_ramp = 0; m_cnt = 0;
      end else if (tick_i) begin
        if (m_cnt == STEP - 1) begin
          m_cnt = 0;
          if (m_ramp < FULL) m_ramp = m_ramp + 1;
        end else m_cnt = m_cnt + 1;
      end
      m_armed = nxt;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit run, act, disch, e_gate, e_dim, e_open;
    int e_duty;
    run = stb_i && vcc_ok_i && vin_ok_i && reg_ok_i;
    act = run && !latch_off_i;
    disch = !stb_i && reg_ok_i && vcc_ok_i;
    e_gate = act && pwm1_i && (m_ramp >= MINL);
    e_duty = e_gate ? ((m_ramp > CAP) ? CAP : m_ramp) : 0;
    e_dim = (act || disch) && pwm1_i && pwm2_i;
    e_open = act && (m_ramp == FULL);
    chk(ss_level_o == m_ramp, "R2/R3/R10/R11 ramp", ss_level_o, m_ramp);
    chk(gate_en_o == e_gate, "R1/R4/R5 gate", gate_en_o, e_gate);
    chk(duty_lim_o == e_duty, "R6 duty", duty_lim_o, e_duty);
    chk(dim_o == e_dim, "R7/R9 dim", dim_o, e_dim);
    chk(open_en_o == e_open, "R8 open", open_en_o, e_open);
    chk(reg_dis_o == disch, "R9 discharge", reg_dis_o, disch);
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      compare();
      cyc_n++;
      tick_i = (cyc_n % tick_div) == 0;
    end
  endtask

  task automatic all_ok(input bit v);
    stb_i = v; vcc_ok_i = v; vin_ok_i = v; reg_ok_i = v;
  endtask

  initial begin
    #20000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    chk(!gate_en_o && !dim_o && !open_en_o && !reg_dis_o && ss_level_o == 0,
        "R1 reset state", gate_en_o, 0);
    rst_ni = 1;
    cyc(3);
    // R1: one flag missing at a time
    stb_i = 1; vcc_ok_i = 1; vin_ok_i = 1; pwm1_i = 1; pwm2_i = 1; cyc(4);
    chk(ss_level_o == 0 && !gate_en_o, "R1 reg flag missing", ss_level_o, 0);
    pwm2_i = 0; reg_ok_i = 1; cyc(10);
    // R2: only pwm1 high, not armed
    chk(ss_level_o == 0, "R2 single pwm no arm", ss_level_o, 0);
    pwm2_i = 1; cyc(1); pwm2_i = 0; cyc(8);
    chk(ss_level_o != 0, "R2 armed after pair", ss_level_o, 1);
    // R4: pwm2 toggling against steady pwm1 through threshold
    for (int k = 0; k < 40; k++) begin pwm2_i = k[0]; cyc(1); end
    chk(ss_level_o >= MINL, "R5 ramp crossed min", ss_level_o, MINL);
    pwm1_i = 0; pwm2_i = 1; cyc(4);
    chk(!gate_en_o, "R4 gate needs pwm1", gate_en_o, 0);
    pwm1_i = 1; tick_div = 3; cyc(60);
    tick_div = 1; cyc(200);
    chk(ss_level_o == FULL && open_en_o, "R8 open at full", ss_level_o, FULL);
    chk(duty_lim_o == CAP, "R6 duty clamp", duty_lim_o, CAP);
    // R11: latch-off
    latch_off_i = 1; cyc(5);
    chk(!gate_en_o && !dim_o && ss_level_o == 0, "R11 latch", ss_level_o, 0);
    latch_off_i = 0; cyc(30);
    // R3: each flag drops for one cycle
    vin_ok_i = 0; cyc(1); vin_ok_i = 1; pwm2_i = 0; cyc(5);
    chk(ss_level_o == 0, "R3 vin drop clears", ss_level_o, 0);
    pwm2_i = 1; cyc(20); vcc_ok_i = 0; cyc(1); vcc_ok_i = 1; cyc(20);
    reg_ok_i = 0; cyc(1); reg_ok_i = 1; cyc(20);
    // R9: standby falls, discharge window
    stb_i = 0; cyc(2);
    chk(reg_dis_o && dim_o && !gate_en_o, "R9 discharge window", dim_o, 1);
    for (int k = 0; k < 8; k++) begin pwm1_i = k[1]; pwm2_i = k[0]; cyc(1); end
    reg_ok_i = 0; pwm1_i = 1; pwm2_i = 1; cyc(3);
    chk(!dim_o && !reg_dis_o, "R9 full shutdown", dim_o, 0);
    // R12: standby back, needs fresh pair
    pwm2_i = 0; all_ok(1); cyc(10);
    chk(ss_level_o == 0, "R12 no start without pair", ss_level_o, 0);
    pwm2_i = 1; cyc(150);
    chk(ss_level_o == FULL, "R10 saturates", ss_level_o, FULL);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule